// File: doc/BRIEF.md
# Test-and-Reset-Bits Read-Modify-Write Sequencer

This block runs one memory instruction, test-and-reset-bits, with the exact bus timing of that instruction. After a start strobe it captures the accumulator, the width flag, the direct-page base, the program counter and the status byte. It fetches the opcode byte. One opcode value selects a full 16-bit address and another selects an 8-bit offset from the direct-page base. The block then fetches the operand bytes, reads the memory operand, and spends one internal cycle on the bit operation. Last, it writes the operand back with every bit that is set in the accumulator cleared.

The zero flag reports whether the accumulator AND the operand is zero, taken at the active width. The remaining status bits pass through unchanged. The memory bus is synchronous and carries one access per cycle. Read data is taken in the same cycle as the read strobe. A one-cycle done strobe marks the end of the instruction. The surrounding core then commits the returned status byte and may start the next instruction in that same cycle.

Top module: `trb_seq`

## Requirements
- R1: While reset is low and after reset, with no start, mem_rd, mem_wr and done are 0 and flags_out is 0.
- R2: Opcode 0x1C uses the address formed from the byte at pc+1 (low) and the byte at pc+2 (high). With narrow=1 the instruction takes 6 cycles from the opcode fetch to the final write, both included.
- R3: Opcode 0x14 uses the address dp + byte at pc+1 (zero-extended), modulo 2^16. With narrow=1 and dp[7:0]==0 it takes 5 cycles.
- R4: With opcode 0x14 and dp[7:0]!=0, one extra cycle with no bus access follows the operand fetch.
- R5: With narrow=0 both forms take 2 more cycles. The block reads the address, then address+1 (wrapping modulo 2^16). After the modify cycle it writes address+1 first and the address last.
- R6: The value written is operand AND NOT accumulator at the active width. With narrow=1 only the byte at the address is written, and the byte at address+1 keeps its value.
- R7: flags_out bit 1 (zero) is 1 when accumulator AND operand is 0 at the active width and 0 otherwise. Every other bit of flags_out equals flags_in as captured at start.
- R8: done is high for exactly one cycle, the cycle after the final write. A start in that cycle begins the next instruction at once.
- R9: Any other opcode performs only the opcode fetch. done follows in the next cycle, nothing is written, and flags_out equals flags_in.
- R10: While an instruction runs, start and the acc_in, dp_in, pc_in, narrow and flags_in inputs are ignored. The values captured at start are used.
- R11: No cycle has both mem_rd and mem_wr. The bus is idle (no read, no write) exactly in the modify cycle and the direct-page extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction; taken only when idle |
| narrow | input | 1 | 1: 8-bit accumulator, 0: 16-bit |
| acc_in | input | 16 | Accumulator value |
| dp_in | input | ADDR_W | Direct-page base register |
| pc_in | input | ADDR_W | Address of the opcode byte |
| flags_in | input | FLAG_W | Status byte before the instruction |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_rd is high |
| mem_addr | output | ADDR_W | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle end-of-instruction strobe |
| flags_out | output | FLAG_W | Status byte after the instruction |

## Verification
The bench targets the direct-page base with a nonzero low byte. A design that skipped the extra cycle would finish one cycle early, and one that tested the whole base would add the cycle where it does not belong. It places a 16-bit operand at 0xFFFF so the high byte wraps to 0x0000, and checks that the high byte is written before the low one. In 8-bit mode it gives the upper accumulator and operand bytes overlapping bits, so a zero flag taken at full width would come out wrong. It also holds start and changes the inputs while an instruction runs, issues a start in the done cycle, and uses a foreign opcode that must leave memory and flags untouched.

// File: rtl/trb_pkg.sv
package trb_pkg;
   localparam int BYTE_W = 8;
   localparam int LANES  = 2;
   localparam int WORD_W = BYTE_W * LANES;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPC,   // opcode fetch
      ST_ADL,   // first operand byte (low address or offset)
      ST_ADH,   // high address byte, absolute form only
      ST_DPW,   // direct-page base misaligned: bus idle
      ST_RDL,   // operand low byte
      ST_RDH,   // operand high byte, wide only
      ST_MOD,   // internal modify cycle: bus idle
      ST_WRH,   // write high byte, wide only
      ST_WRL    // write low byte, last access
   } trb_state_e;
endpackage

// File: rtl/trb_bitop.sv
module trb_bitop
   import trb_pkg::*;
#(
   parameter int LANE_W = BYTE_W,
   parameter int NLANE  = LANES
) (
   input  logic [LANE_W*NLANE-1:0] acc,
   input  logic [LANE_W*NLANE-1:0] opnd,
   input  logic                    wide,
   output logic [LANE_W*NLANE-1:0] res,
   output logic                    zero
);
   logic [NLANE-1:0] hit;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [LANE_W-1:0] a_l;
      logic [LANE_W-1:0] m_l;
      assign a_l = acc[l*LANE_W +: LANE_W];
      assign m_l = opnd[l*LANE_W +: LANE_W];
      assign res[l*LANE_W +: LANE_W] = m_l & ~a_l;
      if (l == 0) begin : g_base
         assign hit[l] = |(a_l & m_l);
      end else begin : g_upper
         assign hit[l] = wide & (|(a_l & m_l));
      end
   end

   assign zero = ~|hit;
endmodule

// File: rtl/trb_agen.sv
module trb_agen
   import trb_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  trb_state_e        state,
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [ADDR_W-1:0] ea_q,
   input  logic [ADDR_W-1:0] dp_q,
   input  logic [BYTE_W-1:0] lo_q,
   input  logic [BYTE_W-1:0] rdata,
   input  logic              abs_mode,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic              wr,
   output logic [ADDR_W-1:0] ea_d
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] ea_p1;
   assign ea_p1 = ea_q + ONE;

   // absolute: {high byte on bus, latched low byte}; direct: base + offset
   assign ea_d = abs_mode ? ADDR_W'({rdata, lo_q})
                          : dp_q + ADDR_W'(rdata);

   always_comb begin
      addr = '0;
      rd   = 1'b0;
      wr   = 1'b0;
      unique case (state)
         ST_OPC: begin addr = pc_q;        rd = 1'b1; end
         ST_ADL: begin addr = pc_q + ONE;  rd = 1'b1; end
         ST_ADH: begin addr = pc_q + TWO;  rd = 1'b1; end
         ST_RDL: begin addr = ea_q;        rd = 1'b1; end
         ST_RDH: begin addr = ea_p1;       rd = 1'b1; end
         ST_WRH: begin addr = ea_p1;       wr = 1'b1; end
         ST_WRL: begin addr = ea_q;        wr = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/trb_ctrl.sv
module trb_ctrl
   import trb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       opc_ok,
   input  logic       abs_mode,
   input  logic       dp_nz,
   input  logic       wide,
   output trb_state_e state_q,
   output logic       done_q
);
   trb_state_e state_d;
   logic       done_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_OPC;
         ST_OPC:  state_d = opc_ok ? ST_ADL : ST_IDLE;
         ST_ADL:  state_d = abs_mode ? ST_ADH : (dp_nz ? ST_DPW : ST_RDL);
         ST_ADH:  state_d = ST_RDL;
         ST_DPW:  state_d = ST_RDL;
         ST_RDL:  state_d = wide ? ST_RDH : ST_MOD;
         ST_RDH:  state_d = ST_MOD;
         ST_MOD:  state_d = wide ? ST_WRH : ST_WRL;
         ST_WRH:  state_d = ST_WRL;
         ST_WRL:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign done_d = (state_q == ST_WRL) || ((state_q == ST_OPC) && !opc_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end
endmodule

// File: rtl/trb_seq.sv
module trb_seq
   import trb_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          FLAG_W  = 8,
   parameter int          ZF_POS  = 1,
   parameter logic [7:0]  OPC_ABS = 8'h1C,
   parameter logic [7:0]  OPC_DIR = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              narrow,
   input  logic [WORD_W-1:0] acc_in,
   input  logic [ADDR_W-1:0] dp_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              done,
   output logic [FLAG_W-1:0] flags_out
);
   if (ADDR_W < WORD_W) begin : g_bad_addr_w
      $error("trb_seq: ADDR_W must hold a two-byte address");
   end
   if (ZF_POS < 0 || ZF_POS >= FLAG_W) begin : g_bad_zf_pos
      $error("trb_seq: ZF_POS outside the status byte");
   end
   if (OPC_ABS == OPC_DIR) begin : g_bad_opc
      $error("trb_seq: the two opcode values must differ");
   end

   trb_state_e        state_q;
   logic              busy_w;
   logic              opc_ok;
   logic              abs_q;
   logic              wide_q;
   logic [WORD_W-1:0] acc_q;
   logic [ADDR_W-1:0] dp_q;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] ea_q;
   logic [ADDR_W-1:0] ea_d;
   logic [BYTE_W-1:0] lo_q;
   logic [WORD_W-1:0] dat_q;
   logic [WORD_W-1:0] res_q;
   logic [WORD_W-1:0] res_d;
   logic              zero_d;
   logic [FLAG_W-1:0] flg_q;

   assign busy_w = (state_q != ST_IDLE);
   assign opc_ok = (mem_rdata == OPC_ABS) || (mem_rdata == OPC_DIR);

   trb_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .opc_ok   (opc_ok),
      .abs_mode (abs_q),
      .dp_nz    (dp_q[BYTE_W-1:0] != '0),
      .wide     (wide_q),
      .state_q  (state_q),
      .done_q   (done)
   );

   trb_agen #(.ADDR_W(ADDR_W)) u_agen (
      .state    (state_q),
      .pc_q     (pc_q),
      .ea_q     (ea_q),
      .dp_q     (dp_q),
      .lo_q     (lo_q),
      .rdata    (mem_rdata),
      .abs_mode (abs_q),
      .addr     (mem_addr),
      .rd       (mem_rd),
      .wr       (mem_wr),
      .ea_d     (ea_d)
   );

   trb_bitop #(.LANE_W(BYTE_W), .NLANE(LANES)) u_bitop (
      .acc  (acc_q),
      .opnd (dat_q),
      .wide (wide_q),
      .res  (res_d),
      .zero (zero_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abs_q  <= 1'b0;
         wide_q <= 1'b0;
         acc_q  <= '0;
         dp_q   <= '0;
         pc_q   <= '0;
         ea_q   <= '0;
         lo_q   <= '0;
         dat_q  <= '0;
         res_q  <= '0;
         flg_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               acc_q  <= acc_in;
               dp_q   <= dp_in;
               pc_q   <= pc_in;
               wide_q <= ~narrow;
               flg_q  <= flags_in;
            end
            ST_OPC: abs_q <= (mem_rdata == OPC_ABS);
            ST_ADL: begin
               lo_q <= mem_rdata;
               if (!abs_q) ea_q <= ea_d;
            end
            ST_ADH: ea_q <= ea_d;
            ST_RDL: dat_q <= {{BYTE_W{1'b0}}, mem_rdata};
            ST_RDH: dat_q[WORD_W-1:BYTE_W] <= mem_rdata;
            ST_MOD: begin
               res_q         <= res_d;
               flg_q[ZF_POS] <= zero_d;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_wdata = '0;
      if (state_q == ST_WRH) mem_wdata = res_q[WORD_W-1:BYTE_W];
      else if (state_q == ST_WRL) mem_wdata = res_q[BYTE_W-1:0];
   end

   assign flags_out = flg_q;
endmodule

// File: rtl/trb_chk.sv
module trb_chk #(
   parameter int ADDR_W = 16,
   parameter int FLAG_W = 8,
   parameter int ZF_POS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic [FLAG_W-1:0] flags_out
);
   localparam logic [FLAG_W-1:0] KEEP = ~(FLAG_W'(1) << ZF_POS);

   AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr)); // R1

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R8

   AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> (done || (mem_wr && mem_addr == ADDR_W'($past(mem_addr) - 1'b1)))); // R5

   AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (((flags_out ^ $past(flags_out)) & KEEP) == '0)); // R7
endmodule

bind trb_seq trb_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .ZF_POS(ZF_POS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy_w),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .done      (done),
   .flags_out (flags_out)
);

// File: tb/tb_trb_seq.sv
module tb_trb_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        narrow = 1'b1;
   logic [15:0] acc_in = '0;
   logic [15:0] dp_in = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  flags_in = '0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [7:0]  mem_wdata;
   logic        done;
   logic [7:0]  flags_out;

   logic [7:0]  mem [0:4095];
   int          checks = 0;
   int          fails = 0;

   always #4ns clk = ~clk;   // 8 ns period

   assign mem_rdata = mem[mem_addr[11:0]];

   trb_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .narrow(narrow),
      .acc_in(acc_in), .dp_in(dp_in), .pc_in(pc_in), .flags_in(flags_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done), .flags_out(flags_out)
   );

   function automatic logic [11:0] ix(input logic [15:0] a);
      return a[11:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Runs one instruction; returns at the negedge where done is high.
   task automatic run(input logic [7:0] op, input bit nar, input logic [15:0] acc,
                      input logic [15:0] dp, input logic [7:0] off,
                      input logic [15:0] absa, input logic [7:0] flg,
                      input int gap, input bit hold);
      logic [15:0] ea, pc, m, a, r, wa0;
      logic [7:0]  d0, d1, fexp;
      bit          is_abs, is_dp, known, pen, z;
      int          cyc, nidle, nwr, ecyc;
      string       creq;
      is_abs = (op == 8'h1C);
      is_dp  = (op == 8'h14);
      known  = is_abs || is_dp;
      pen    = is_dp && (dp[7:0] != 8'h00);
      ea     = is_abs ? absa : dp + {8'h00, off};
      pc     = ea + 16'h0800 + 16'($urandom_range(0, 255));
      if (gap > 0) begin
         repeat (gap) @(negedge clk);
         chk(!done && !mem_rd && !mem_wr, "R8", "quiet after done",
             {done, mem_rd, mem_wr}, 0);
      end
      mem[ix(pc)] = op;
      mem[ix(pc + 16'd1)] = is_abs ? absa[7:0] : off;
      mem[ix(pc + 16'd2)] = absa[15:8];
      mem[ix(ea)] = 8'($urandom);
      mem[ix(ea + 16'd1)] = 8'($urandom);
      d0 = mem[ix(ea)];
      d1 = mem[ix(ea + 16'd1)];
      m  = nar ? {8'h00, d0} : {d1, d0};
      a  = nar ? {8'h00, acc[7:0]} : acc;
      r  = m & ~a;
      z  = ((a & m) == 16'h0000);
      fexp = known ? ((flg & 8'hFD) | (z ? 8'h02 : 8'h00)) : flg;
      ecyc = known ? ((is_abs ? 6 : 5) + (nar ? 0 : 2) + (pen ? 1 : 0)) : 1;
      creq = !known ? "R9" : !nar ? "R5" : pen ? "R4" : is_abs ? "R2" : "R3";
      narrow = nar; acc_in = acc; dp_in = dp; pc_in = pc; flags_in = flg;
      start = 1'b1;
      @(negedge clk);
      start = hold;
      cyc = 0; nidle = 0; nwr = 0; wa0 = '0;
      while (!done && cyc < 40) begin
         if (!mem_rd && !mem_wr) nidle++;
         if (mem_wr) begin
            if (nwr == 0) wa0 = mem_addr;
            mem[ix(mem_addr)] = mem_wdata;
            nwr++;
         end
         cyc++;
         if (hold) begin   // R10: disturb inputs while running
            acc_in = ~acc; dp_in = ~dp; pc_in = ~pc; narrow = ~nar; flags_in = ~flg;
            if (cyc >= 2) start = 1'b0;
         end
         @(negedge clk);
      end
      chk(cyc == ecyc, hold ? "R10" : creq, "cycle count", cyc, ecyc);
      chk(nidle == (known ? (pen ? 2 : 1) : 0), "R11", "idle bus cycles",
          nidle, known ? (pen ? 2 : 1) : 0);
      chk(nwr == (known ? (nar ? 1 : 2) : 0), known ? "R6" : "R9", "write count",
          nwr, known ? (nar ? 1 : 2) : 0);
      if (known) begin
         chk(mem[ix(ea)] == r[7:0], "R6", "low byte written", mem[ix(ea)], r[7:0]);
         chk(mem[ix(ea + 16'd1)] == (nar ? d1 : r[15:8]), "R6", "high byte",
             mem[ix(ea + 16'd1)], nar ? d1 : r[15:8]);
         if (!nar) chk(wa0 == ea + 16'd1, "R5", "first write address", wa0, ea + 16'd1);
      end
      chk(flags_out == fexp, known ? "R7" : "R9", "flags", flags_out, fexp);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(!mem_rd && !mem_wr && !done && flags_out == 8'h00, "R1", "in reset",
          {mem_rd, mem_wr, done, flags_out}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!mem_rd && !mem_wr && !done && flags_out == 8'h00, "R1", "after reset",
          {mem_rd, mem_wr, done, flags_out}, 0);
      // directed corners
      run(8'h1C, 1, 16'h0F0F, 16'h0000, 8'h00, 16'h1234, 8'hFF, 1, 0); // R2
      run(8'h14, 1, 16'h00F0, 16'h3300, 8'h42, 16'h0000, 8'h00, 1, 0); // R3
      run(8'h14, 1, 16'h0081, 16'h3301, 8'h42, 16'h0000, 8'h5A, 1, 0); // R4
      run(8'h1C, 0, 16'hA5C3, 16'h0000, 8'h00, 16'h4000, 8'hA5, 1, 0); // R5
      run(8'h14, 0, 16'hFFFF, 16'hFFF0, 8'h0F, 16'h0000, 8'h00, 1, 0); // R5 wrap
      run(8'h14, 1, 16'hFF00, 16'h2000, 8'h10, 16'h0000, 8'h00, 1, 0); // R7 upper ignored
      run(8'h1C, 1, 16'h0000, 16'h0000, 8'h00, 16'h0777, 8'h7D, 1, 0); // R7 zero acc
      run(8'hEA, 0, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 8'hC3, 1, 0); // R9
      run(8'h1C, 0, 16'h1111, 16'h0000, 8'h00, 16'h5555, 8'h11, 1, 1); // R10
      run(8'h14, 1, 16'h0003, 16'h0100, 8'h20, 16'h0000, 8'h22, 0, 0); // R8 chained
      for (int n = 0; n < 150; n++) begin
         logic [7:0]  op;
         logic [15:0] dp;
         int          sel;
         bit          hold;
         sel = $urandom_range(0, 9);
         op  = (sel < 5) ? 8'h1C : (sel < 9) ? 8'h14 : 8'(8'h20 + 8'($urandom_range(0, 15)));
         dp  = 16'($urandom);
         if ($urandom_range(0, 1) == 0) dp[7:0] = 8'h00;
         hold = (op == 8'h1C || op == 8'h14) && ($urandom_range(0, 3) == 0);
         run(op, 1'($urandom), 16'($urandom), dp, 8'($urandom), 16'($urandom),
             8'($urandom), $urandom_range(0, 2), hold);
      end
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule